// File: doc/BRIEF.md
# Encoded SPI Serial Clock Divider

This block derives the serial clock of a SPI flash interface from the bus clock. The divisor comes from a chip-select control word. A 4-bit code field selects a base ratio of 1 to 16 through a scrambled, non-binary encoding. A 4-bit extension field adds whole multiples of 16 to that ratio. A legacy selection bit instead multiplies the base ratio by four and ignores the extension field.

The block decodes the control word into an integer divisor and runs a phase counter while chip select is active. It drives a registered serial clock that idles low, with a low phase followed by a high phase in each period. For the shift register it gives one-cycle strobes, each asserted in the bus-clock cycle just before a serial-clock edge. Software chooses the control word. The block only decodes and times it.

Top module: `spi_sclk_gen`

## Requirements
- R1: With the legacy bit (bit 13) clear and the extension field zero, the code c in bits [11:8] gives divisor n = 31 - 2c when c >= 8 and n = 16 - 2c when c < 8. Ratios 1..16 therefore map to codes 15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0.
- R2: With bit 13 clear, the extension field e in bits [27:24] makes the divisor n + 16*e.
- R3: With bit 13 set, the divisor is 4*n and bits [27:24] have no effect.
- R4: The combination n = 1, e = 0 with bit 13 clear is not a legal ratio. The block then divides by 2.
- R5: For divisor D, each serial-clock period lasts D bus cycles: floor(D/2) cycles low, then ceil(D/2) cycles high. An odd D makes the high phase one cycle longer.
- R6: After reset and while cs_active_i is low, sclk_o, rise_stb_o and fall_stb_o are low. The strobes drop in the same cycle cs_active_i drops, and sclk_o is low from the next bus cycle on.
- R7: Each transfer start reloads the phase counter. Counting the first cycle with cs_active_i high as cycle 0, sclk_o at cycle t is high exactly when (t mod D) >= floor(D/2), whatever state a previous transfer ended in.
- R8: rise_stb_o is high only in cycles where (t mod D) = floor(D/2) - 1, and fall_stb_o only where (t mod D) = D - 1. Each strobe therefore precedes the matching sclk_o edge by one cycle, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | CTRL_W | Chip-select control word carrying the code, extension and legacy fields |
| cs_active_i | input | 1 | Chip select active; low idles the clock and clears the counter |
| sclk_o | output | 1 | Serial clock, idle low |
| rise_stb_o | output | 1 | One-cycle strobe before each sclk_o rising edge |
| fall_stb_o | output | 1 | One-cycle strobe before each sclk_o falling edge |

## Verification
The serial clock and both strobes are compared cycle by cycle over two or more full periods against a waveform built from the expected divisor. The tests cover even and odd divisors (2, 3, 15, 16), the extreme codes 15 and 0, an extension-field ratio and the largest ratio of 256. The two legacy cases each use a nonzero extension field, so a design that wrongly adds the field produces a different period. The illegal divide-by-1 word must give exactly the divide-by-2 waveform. A transfer cut off in its high phase and restarted after one idle cycle must restart from the low phase, which shows the counter reload.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  localparam int CODE_W = 4;

  // Scrambled code -> ratio 1..16
  function automatic logic [4:0] code_to_ratio(input logic [CODE_W-1:0] c);
    if (c[CODE_W-1]) return 5'd31 - {c, 1'b0};
    else             return 5'd16 - {c, 1'b0};
  endfunction
endpackage

// File: rtl/sclk_div_decode.sv
module sclk_div_decode
  import spi_sclk_pkg::*;
#(
  parameter int CTRL_W     = 32,
  parameter int CODE_LSB   = 8,
  parameter int BASE_LSB   = 24,
  parameter int BASE_W     = 4,
  parameter int LEGACY_BIT = 13,
  parameter int DIV_W      = BASE_W + 5
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [DIV_W-1:0]  div_o
);
  logic [4:0]        ratio;
  logic [BASE_W-1:0] ext;
  logic [DIV_W-1:0]  raw;

  always_comb begin
    ratio = code_to_ratio(ctrl_i[CODE_LSB +: CODE_W]);
    ext   = ctrl_i[BASE_LSB +: BASE_W];
    if (ctrl_i[LEGACY_BIT]) raw = DIV_W'({ratio, 2'b00});
    else                    raw = DIV_W'(ratio) + (DIV_W'(ext) << 4);
    // divide-by-1 is illegal: fall back to 2
    div_o = (raw == DIV_W'(1)) ? DIV_W'(2) : raw;
  end
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nx, low_len, last;
  logic             sclk_q;

  assign low_len = div_i >> 1;
  assign last    = div_i - DIV_W'(1);

  always_comb begin
    if (!active_i)          cnt_nx = '0;
    else if (cnt_q >= last) cnt_nx = '0;  // also covers a shrunk divisor
    else                    cnt_nx = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      sclk_q <= active_i && (cnt_nx >= low_len);
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = active_i && (cnt_q == low_len - DIV_W'(1));
  assign fall_o = active_i && (cnt_q == last);

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !sclk_o);
  assert_rise_leads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sclk_o);
  assert_fall_leads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !sclk_o);
  assert_rose_has_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(rise_o));
  assert_strobes_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int CTRL_W     = 32,
  parameter int CODE_LSB   = 8,
  parameter int BASE_LSB   = 24,
  parameter int BASE_W     = 4,
  parameter int LEGACY_BIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cs_active_i,
  output logic              sclk_o,
  output logic              rise_stb_o,
  output logic              fall_stb_o
);
  localparam int DIV_W = BASE_W + 5;

  logic [DIV_W-1:0] div;

  sclk_div_decode #(
    .CTRL_W(CTRL_W), .CODE_LSB(CODE_LSB), .BASE_LSB(BASE_LSB),
    .BASE_W(BASE_W), .LEGACY_BIT(LEGACY_BIT), .DIV_W(DIV_W)
  ) u_dec (
    .ctrl_i(ctrl_i),
    .div_o (div)
  );

  sclk_phase_gen #(.DIV_W(DIV_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(cs_active_i),
    .div_i   (div),
    .sclk_o  (sclk_o),
    .rise_o  (rise_stb_o),
    .fall_o  (fall_stb_o)
  );

  assert_legacy_mult4_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[LEGACY_BIT] |-> (div[1:0] == 2'b00 && div >= DIV_W'(4) && div <= DIV_W'(64)));
  assert_ext_extends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[LEGACY_BIT] && ctrl_i[BASE_LSB +: BASE_W] != '0) |-> div > DIV_W'(16));
  assert_no_div1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div >= DIV_W'(2));
endmodule

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl = '0;
  logic        cs = 1'b0;
  logic        sclk, rise, fall;
  int checks = 0;
  int errs = 0;

  spi_sclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl), .cs_active_i(cs),
    .sclk_o(sclk), .rise_stb_o(rise), .fall_stb_o(fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input int code, input int ext, input bit legacy);
    logic [31:0] v = '0;
    v[11:8]  = 4'(code);
    v[27:24] = 4'(ext);
    v[13]    = legacy;
    return v;
  endfunction

  // Expected divisor from the requirement tables
  function automatic int exp_div(input logic [31:0] v);
    int tbl [16] = '{15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0};
    int n = 0;
    int d;
    for (int i = 0; i < 16; i++) if (tbl[i] == int'(v[11:8])) n = i + 1;
    if (v[13]) d = 4 * n;
    else       d = n + 16 * int'(v[27:24]);
    if (d == 1) d = 2;
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // One transfer: cs low one cycle, then compare the waveform over 2 periods + 3
  task automatic run_case(input logic [31:0] v, input string req);
    int d = exp_div(v);
    int l = d / 2;
    int bad_clk = 0, bad_stb = 0;
    int a_clk = 0, e_clk = 0, a_stb = 0, e_stb = 0;
    @(negedge clk); cs = 1'b0; ctrl = v;
    @(negedge clk); cs = 1'b1;
    for (int t = 0; t < 2 * d + 3; t++) begin
      int ph = t % d;
      bit es = (ph >= l);
      int est = ((ph == l - 1) ? 2 : 0) + ((ph == d - 1) ? 1 : 0);
      #1;
      if (sclk !== es && bad_clk == 0) begin
        bad_clk = t + 1; a_clk = int'(sclk); e_clk = int'(es);
      end
      if (int'({rise, fall}) != est && bad_stb == 0) begin
        bad_stb = t + 1; a_stb = int'({rise, fall}); e_stb = est;
      end
      @(negedge clk);
    end
    check(bad_clk == 0, req, $sformatf("sclk D=%0d cycle %0d", d, bad_clk - 1), a_clk, e_clk);
    check(bad_stb == 0, "R8", $sformatf("strobes D=%0d cycle %0d", d, bad_stb - 1), a_stb, e_stb);
  endtask

  task automatic reset_idle_test();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(!sclk && !rise && !fall, "R6", "idle after reset", int'({sclk, rise, fall}), 0);
    end
  endtask

  task automatic drop_restart_test();
    @(negedge clk); cs = 1'b0; ctrl = mk(0, 0, 0);  // D=16
    @(negedge clk); cs = 1'b1;
    repeat (10) @(negedge clk);                     // cycle 10: high phase
    #1;
    check(sclk === 1'b1, "R5", "high phase before drop", int'(sclk), 1);
    cs = 1'b0; #1;
    check(!rise && !fall, "R6", "strobes on drop", int'({rise, fall}), 0);
    @(negedge clk); #1;
    check(sclk === 1'b0, "R6", "sclk after drop", int'(sclk), 0);
    run_case(mk(0, 0, 0), "R7");                     // reload from low phase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    reset_idle_test();
    run_case(mk(7, 0, 0),  "R1");   // D=2
    run_case(mk(14, 0, 0), "R5");   // D=3 odd
    run_case(mk(8, 0, 0),  "R1");   // D=15
    run_case(mk(0, 0, 0),  "R1");   // D=16
    run_case(mk(15, 0, 0), "R4");   // illegal -> 2
    run_case(mk(4, 2, 0),  "R2");   // 8+32=40
    run_case(mk(0, 15, 0), "R2");   // 256
    run_case(mk(6, 5, 1),  "R3");   // 4*4=16, ext ignored
    run_case(mk(15, 9, 1), "R3");   // 4*1=4, ext ignored
    drop_restart_test();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule